// File: doc/BRIEF.md
# Prefix-Modified Opcode Remapping Decoder

This decode-stage block sits behind the fetch unit of an 8-bit accumulator processor and turns a stream of fetched bytes into one micro-operation descriptor per instruction. Two optional prefix bytes may come ahead of a base opcode. The register-override prefix makes the instructions that normally use index register Y use the stack pointer S. The same prefix turns the X-to-stack transfer into an X-to-Y transfer. The indirection prefix adds one level of indirection to the zero-page, zero-page-indexed and absolute addressing forms.

The prefixes may arrive in either order, and a repeated prefix byte has the same effect as a single one. They do not open a second opcode page: they rewrite the register operand, the addressing mode and the cycle estimate of an opcode that already exists. The prefix state is dropped once a base opcode has been accepted. It is also dropped when an interrupt is accepted, and on reset. Operand fetch, execution and bus sequencing are handled by later stages.

Top module: `prefix_remap_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `uop_valid` goes low after that edge and both prefix flags are cleared.
- R2: A byte equal to `REG_PFX_CODE` (default 8'h03) or `IND_PFX_CODE` (default 8'h13) produces no descriptor. Its effect is held until the next base opcode. The two prefixes may come in either order, and repeats have no further effect.
- R3: A base byte accepted at a clock edge (`byte_valid` high, `irq_ack` low) makes `uop_valid` high for exactly the following cycle. The descriptor fields hold the decode of that byte.
- R4: The Y-register opcodes are LDY imm A0, zp A4, zp,X B4, abs AC; CPY imm C0, zp C4, abs CC; STY zp 84, zp,X 94, abs 8C; DEY 88; INY C8; TAY A8; PLY 7A. Without the override they report register Y (`uop_reg`=0); with the override they report S (`uop_reg`=1). The operation codes are load 0, compare 1, store 2, decrement 3, increment 4, transfer-from-A 5, pull 6, transfer-from-X 7 and pass-through 15.
- R5: TXS (9A) reports op 7 with register S, and with the override prefix reports register Y.
- R6: With the indirection prefix, mode zp (1) becomes zp-indirect (5), zp,X (2) becomes zp-indexed-indirect (6), and abs (3) becomes abs-indirect (7), and `uop_ind` is 1.
- R7: Immediate (mode 0) and implied (mode 4) forms keep their mode under the indirection prefix, and `uop_ind` stays 0.
- R8: `uop_cycles` for a listed opcode equals the base cost, plus 1 per prefix present, plus 2 more when indirection applies to a memory form. The base costs are imm 2, zp 3, zp,X 3, abs 4 and implied 1. This gives 3/4/4/5/2 with one prefix and 4/7/7/8/3 with both.
- R9: Prefix state is cleared after every accepted base opcode, whether it is listed or not.
- R10: `irq_ack` high at a clock edge clears the prefix state. A byte presented in that same cycle is discarded and produces no descriptor.
- R11: The indirection prefix without the override, ahead of an unlisted opcode, sets `uop_illegal`. In every other case `uop_illegal` is 0.
- R12: An unlisted opcode reports op 15, register NONE (3), mode NONE (15), `uop_ind` 0 and cycles 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | A fetched byte is presented this cycle |
| byte_in | input | 8 | Fetched byte |
| irq_ack | input | 1 | Interrupt accepted; drops prefix state |
| uop_valid | output | 1 | Descriptor valid for one cycle |
| uop_byte | output | 8 | Base opcode byte that was decoded |
| uop_op | output | 4 | Operation code |
| uop_reg | output | 2 | Register select: 0 Y, 1 S, 3 none |
| uop_mode | output | 4 | Addressing mode after remapping |
| uop_ind | output | 1 | An indirection level was added |
| uop_cycles | output | 4 | Expected cycle count |
| uop_illegal | output | 1 | Illegal prefix/opcode combination |

## Verification
The decoder is driven with base opcodes alone, behind the override prefix, behind the indirection prefix, and behind both prefixes in both orders. Comparing these results separates register substitution from mode remapping and from cycle accounting. Back-to-back opcodes, a repeated prefix, and prefixes followed by an interrupt acceptance show whether prefix state leaks from one instruction to the next. Unlisted opcodes placed behind each prefix combination separate pass-through decoding from the illegal-combination flag.

// File: rtl/prd_pkg.sv
// Shared encodings for the prefix remapping decoder.
// Assumes: 4-bit op and mode codes, 2-bit register select.
package prd_pkg;
    typedef enum logic [3:0] {
        OP_LD = 4'd0, OP_CP = 4'd1, OP_ST = 4'd2, OP_DEC = 4'd3,
        OP_INC = 4'd4, OP_XFA = 4'd5, OP_PULL = 4'd6, OP_XFX = 4'd7,
        OP_PASS = 4'd15
    } uop_op_e;

    typedef enum logic [1:0] {
        RG_Y = 2'd0, RG_S = 2'd1, RG_NONE = 2'd3
    } uop_reg_e;

    typedef enum logic [3:0] {
        AM_IMM = 4'd0, AM_ZP = 4'd1, AM_ZPX = 4'd2, AM_ABS = 4'd3,
        AM_IMP = 4'd4, AM_ZPI = 4'd5, AM_ZPXI = 4'd6, AM_ABSI = 4'd7,
        AM_NONE = 4'd15
    } addr_mode_e;

    typedef struct packed {
        uop_op_e    op;
        logic       listed;
        addr_mode_e mode;
        logic       xfer_to_stack;
    } base_dec_t;
endpackage

// File: rtl/prd_opcode_table.sv
// Base opcode lookup: maps one opcode byte to its unprefixed operation
// and addressing mode. Assumes: purely combinational, no prefix knowledge.
module prd_opcode_table
    import prd_pkg::*;
(
    input  logic [7:0] opc,
    output base_dec_t  dec
);
    // Look up the base operation and addressing mode of the opcode.
    always_comb begin
        dec = '{op: OP_PASS, listed: 1'b1, mode: AM_NONE, xfer_to_stack: 1'b0};
        case (opc)
            8'hA0: begin dec.op = OP_LD;   dec.mode = AM_IMM; end
            8'hA4: begin dec.op = OP_LD;   dec.mode = AM_ZP;  end
            8'hB4: begin dec.op = OP_LD;   dec.mode = AM_ZPX; end
            8'hAC: begin dec.op = OP_LD;   dec.mode = AM_ABS; end
            8'hC0: begin dec.op = OP_CP;   dec.mode = AM_IMM; end
            8'hC4: begin dec.op = OP_CP;   dec.mode = AM_ZP;  end
            8'hCC: begin dec.op = OP_CP;   dec.mode = AM_ABS; end
            8'h84: begin dec.op = OP_ST;   dec.mode = AM_ZP;  end
            8'h94: begin dec.op = OP_ST;   dec.mode = AM_ZPX; end
            8'h8C: begin dec.op = OP_ST;   dec.mode = AM_ABS; end
            8'h88: begin dec.op = OP_DEC;  dec.mode = AM_IMP; end
            8'hC8: begin dec.op = OP_INC;  dec.mode = AM_IMP; end
            8'hA8: begin dec.op = OP_XFA;  dec.mode = AM_IMP; end
            8'h7A: begin dec.op = OP_PULL; dec.mode = AM_IMP; end
            8'h9A: begin dec.op = OP_XFX;  dec.mode = AM_IMP; dec.xfer_to_stack = 1'b1; end
            default: dec.listed = 1'b0;
        endcase
    end
endmodule

// File: rtl/prd_prefix_track.sv
// Prefix tracker: recognises the two prefix bytes and holds their flags
// until a base opcode, an interrupt acceptance or a reset clears them.
// Assumes: prefix codes are distinct and are not listed base opcodes.
module prd_prefix_track #(
    parameter logic [7:0] REG_CODE = 8'h03,
    parameter logic [7:0] IND_CODE = 8'h13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_in,
    input  logic       irq_ack,
    output logic       is_prefix,
    output logic       reg_q,
    output logic       ind_q
);
    // Classify the incoming byte as a prefix.
    always_comb is_prefix = (byte_in == REG_CODE) || (byte_in == IND_CODE);

    // Hold prefix flags; set on prefix bytes, clear on base opcode or interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n || irq_ack) begin
            reg_q <= 1'b0;
            ind_q <= 1'b0;
        end else if (byte_valid) begin
            if (is_prefix) begin
                if (byte_in == REG_CODE) reg_q <= 1'b1;
                if (byte_in == IND_CODE) ind_q <= 1'b1;
            end else begin
                reg_q <= 1'b0;
                ind_q <= 1'b0;
            end
        end
    end

    // R9
    pfx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !irq_ack && !is_prefix) |=> (!reg_q && !ind_q));
    // R10
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (!reg_q && !ind_q));
    // R2
    pfx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !irq_ack && is_prefix) |=> (reg_q || ind_q));
endmodule

// File: rtl/prd_remap.sv
// Prefix remapper: applies the prefix flags to a base decode, giving the
// final register, mode, indirection flag, cycle count and illegal flag.
// Assumes: combinational; base costs come from parameters.
module prd_remap
    import prd_pkg::*;
#(
    parameter int CYC_W    = 4,
    parameter int COST_IMM = 2,
    parameter int COST_ZP  = 3,
    parameter int COST_ZPX = 3,
    parameter int COST_ABS = 4,
    parameter int COST_IMP = 1,
    parameter int IND_EXTRA = 2
) (
    input  base_dec_t         dec,
    input  logic              reg_pfx,
    input  logic              ind_pfx,
    output uop_op_e           op,
    output uop_reg_e          rsel,
    output addr_mode_e        mode,
    output logic              ind,
    output logic [CYC_W-1:0]  cycles,
    output logic              illegal
);
    logic             mem_form;
    logic [CYC_W-1:0] base_cost;

    // Decide whether the base mode is a memory form that can take indirection.
    always_comb mem_form = (dec.mode == AM_ZP) || (dec.mode == AM_ZPX) || (dec.mode == AM_ABS);

    // Pick the base cycle cost of the addressing form.
    always_comb begin
        case (dec.mode)
            AM_IMM:  base_cost = CYC_W'(COST_IMM);
            AM_ZP:   base_cost = CYC_W'(COST_ZP);
            AM_ZPX:  base_cost = CYC_W'(COST_ZPX);
            AM_ABS:  base_cost = CYC_W'(COST_ABS);
            AM_IMP:  base_cost = CYC_W'(COST_IMP);
            default: base_cost = '0;
        endcase
    end

    // Apply register override, mode rewrite and cycle accounting.
    always_comb begin
        op      = dec.op;
        illegal = ind_pfx && !reg_pfx && !dec.listed;
        ind     = dec.listed && ind_pfx && mem_form;
        if (!dec.listed)            rsel = RG_NONE;
        else if (dec.xfer_to_stack) rsel = reg_pfx ? RG_Y : RG_S;
        else                        rsel = reg_pfx ? RG_S : RG_Y;
        mode = dec.listed ? dec.mode : AM_NONE;
        if (ind) begin
            case (dec.mode)
                AM_ZP:   mode = AM_ZPI;
                AM_ZPX:  mode = AM_ZPXI;
                default: mode = AM_ABSI;
            endcase
        end
        if (dec.listed)
            cycles = base_cost + CYC_W'(reg_pfx) + CYC_W'(ind_pfx)
                   + (ind ? CYC_W'(IND_EXTRA) : '0);
        else
            cycles = '0;
    end
endmodule

// File: rtl/prefix_remap_decoder.sv
// Top of the prefix remapping decoder: accepts fetched bytes, tracks
// prefixes, and registers one descriptor per accepted base opcode.
// Assumes: one byte per cycle at most; irq_ack wins over a same-cycle byte.
module prefix_remap_decoder
    import prd_pkg::*;
#(
    parameter logic [7:0] REG_PFX_CODE = 8'h03,
    parameter logic [7:0] IND_PFX_CODE = 8'h13,
    parameter int         CYC_W        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic [7:0]       byte_in,
    input  logic             irq_ack,
    output logic             uop_valid,
    output logic [7:0]       uop_byte,
    output logic [3:0]       uop_op,
    output logic [1:0]       uop_reg,
    output logic [3:0]       uop_mode,
    output logic             uop_ind,
    output logic [CYC_W-1:0] uop_cycles,
    output logic             uop_illegal
);
    logic             is_prefix, reg_q, ind_q, fire;
    base_dec_t        dec;
    uop_op_e          n_op;
    uop_reg_e         n_reg;
    addr_mode_e       n_mode;
    logic             n_ind, n_ill;
    logic [CYC_W-1:0] n_cyc;

    prd_prefix_track #(.REG_CODE(REG_PFX_CODE), .IND_CODE(IND_PFX_CODE)) track_i (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
        .irq_ack(irq_ack), .is_prefix(is_prefix), .reg_q(reg_q), .ind_q(ind_q)
    );

    prd_opcode_table table_i (.opc(byte_in), .dec(dec));

    prd_remap #(.CYC_W(CYC_W)) remap_i (
        .dec(dec), .reg_pfx(reg_q), .ind_pfx(ind_q), .op(n_op), .rsel(n_reg),
        .mode(n_mode), .ind(n_ind), .cycles(n_cyc), .illegal(n_ill)
    );

    // A base opcode is accepted when valid, not a prefix, and no interrupt.
    always_comb fire = byte_valid && !irq_ack && !is_prefix;

    // Register the descriptor; valid pulses for one cycle per accepted opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uop_valid   <= 1'b0;
            uop_byte    <= '0;
            uop_op      <= OP_PASS;
            uop_reg     <= RG_NONE;
            uop_mode    <= AM_NONE;
            uop_ind     <= 1'b0;
            uop_cycles  <= '0;
            uop_illegal <= 1'b0;
        end else begin
            uop_valid   <= fire;
            uop_illegal <= fire && n_ill;
            if (fire) begin
                uop_byte   <= byte_in;
                uop_op     <= n_op;
                uop_reg    <= n_reg;
                uop_mode   <= n_mode;
                uop_ind    <= n_ind;
                uop_cycles <= n_cyc;
            end
        end
    end

    // R3
    valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> ($past(byte_valid) && !$past(irq_ack)));
    // R11
    illegal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uop_illegal |-> (uop_op == OP_PASS && uop_reg == RG_NONE));
    // R8
    absi_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_mode == AM_ABSI && uop_reg == RG_S) |-> (uop_cycles == 8));
    // R6
    ind_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ind) |-> (uop_mode >= AM_ZPI && uop_mode <= AM_ABSI));
endmodule

// File: tb/prefix_remap_decoder_tb_top.sv
module prefix_remap_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       irq_ack = 1'b0;
    logic       uop_valid, uop_ind, uop_illegal;
    logic [7:0] uop_byte;
    logic [3:0] uop_op, uop_mode, uop_cycles;
    logic [1:0] uop_reg;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    localparam logic [7:0] PR = 8'h03;
    localparam logic [7:0] PI = 8'h13;

    always #5 clk = ~clk;

    prefix_remap_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
        .irq_ack(irq_ack), .uop_valid(uop_valid), .uop_byte(uop_byte),
        .uop_op(uop_op), .uop_reg(uop_reg), .uop_mode(uop_mode), .uop_ind(uop_ind),
        .uop_cycles(uop_cycles), .uop_illegal(uop_illegal)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one byte for one edge; return at the following negedge.
    task automatic put(input logic [7:0] b);
        byte_valid = 1'b1; byte_in = b;
        @(negedge clk);
        byte_valid = 1'b0; byte_in = 8'h00;
    endtask

    // Check full descriptor: valid, op, reg, mode, ind, cycles, illegal.
    task automatic chk_uop(input string req, input logic [3:0] op, input logic [1:0] rg,
                           input logic [3:0] md, input logic ind, input logic [3:0] cy,
                           input logic ill);
        chk(req, {uop_valid, uop_op, uop_reg, uop_mode, uop_ind, uop_cycles, uop_illegal},
                 {1'b1, op, rg, md, ind, cy, ill});
    endtask

    task automatic t_reset();
        chk("R1 valid low after reset", uop_valid, 0);
        put(8'hA0);  // prefixes must be clear: Y, cost 2
        chk_uop("R1 no prefix left", 0, 0, 0, 0, 2, 0);
    endtask

    task automatic t_plain();
        put(8'hA4); chk_uop("R4 LDY zp plain", 0, 0, 1, 0, 3, 0);
        chk("R3 byte echoed", uop_byte, 8'hA4);
        put(8'h9A); chk_uop("R5 TXS plain", 7, 1, 4, 0, 1, 0);
        @(negedge clk); chk("R3 one-cycle pulse", uop_valid, 0);
    endtask

    task automatic t_override();
        put(PR); chk("R2 prefix gives no descriptor", uop_valid, 0);
        put(8'hA4); chk_uop("R4 LDS zp", 0, 1, 1, 0, 4, 0);
        put(PR); put(8'h88); chk_uop("R4 DES", 3, 1, 4, 0, 2, 0);
        put(PR); put(8'h7A); chk_uop("R4 PLS", 6, 1, 4, 0, 2, 0);
        put(PR); put(8'hB4); chk_uop("R8 LDS zp,X one prefix", 0, 1, 2, 0, 4, 0);
        put(PR); put(8'hAC); chk_uop("R8 LDS abs one prefix", 0, 1, 3, 0, 5, 0);
        put(PR); put(8'hC0); chk_uop("R8 CPS imm one prefix", 1, 1, 0, 0, 3, 0);
        put(PR); put(8'h9A); chk_uop("R5 TXY", 7, 0, 4, 0, 2, 0);
    endtask

    task automatic t_both();
        put(PR); put(PI); put(8'h8C); chk_uop("R6 STS (abs)", 2, 1, 7, 1, 8, 0);
        put(PI); put(PR); put(8'hB4); chk_uop("R6 LDS (zp,X) rev order", 0, 1, 6, 1, 7, 0);
        put(PR); put(PI); put(8'hC4); chk_uop("R6 CPS (zp)", 1, 1, 5, 1, 7, 0);
        put(PR); put(PI); put(8'hC0); chk_uop("R7 CPS imm keeps mode", 1, 1, 0, 0, 4, 0);
        put(PR); put(PI); put(8'hC8); chk_uop("R7 INS implied", 4, 1, 4, 0, 3, 0);
        put(PR); put(PR); put(PI); put(PI); put(8'hA4);
        chk_uop("R2 repeated prefixes", 0, 1, 5, 1, 7, 0);
    endtask

    task automatic t_ind_alone();
        put(PI); put(8'hA4); chk_uop("R8 LDY (zp) ind only", 0, 0, 5, 1, 6, 0);
        put(PI); put(8'hEA); chk_uop("R11 illegal ind alone", 15, 3, 15, 0, 0, 1);
        put(8'hEA); chk_uop("R12 unlisted plain", 15, 3, 15, 0, 0, 0);
        put(PR); put(8'hEA); chk_uop("R11 override no illegal", 15, 3, 15, 0, 0, 0);
        put(PR); put(PI); put(8'hEA); chk_uop("R11 both no illegal", 15, 3, 15, 0, 0, 0);
    endtask

    task automatic t_clear();
        put(PR); put(PI); put(8'hA0); chk_uop("R9 prefixed", 0, 1, 0, 0, 4, 0);
        put(8'hA0); chk_uop("R9 cleared after opcode", 0, 0, 0, 0, 2, 0);
        put(PR); put(8'hEA); put(8'hA4); chk_uop("R9 cleared after unlisted", 0, 0, 1, 0, 3, 0);
    endtask

    task automatic t_irq();
        put(PR); put(PI);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        put(8'hA4); chk_uop("R10 irq drops prefixes", 0, 0, 1, 0, 3, 0);
        irq_ack = 1'b1; put(8'hA0); irq_ack = 1'b0;
        chk("R10 byte during irq ignored", uop_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_override();
        t_both();
        t_ind_alone();
        t_clear();
        t_irq();
        rst_n = 1'b0; @(negedge clk);
        chk("R1 reset drops valid", uop_valid, 0);
        rst_n = 1'b1;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule